// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the multiply and divide engine of a 32-bit integer core. It owns the two result registers, HI and LO. The core pulses `start` with a 6-bit function code and the two source operand values. For a multiply or a divide, the unit iterates over many cycles. It holds `busy` while it works. It then writes both halves of the result at once and pulses `done`.

The same unit also serves the four move operations. Two of them read HI or LO onto `rd_data`. The other two load HI or LO from `move_in` in a single cycle. A multiply leaves the low half of the 64-bit product in LO and the high half in HI. A divide leaves the quotient in LO and the remainder in HI. A zero divisor clears both registers and raises no fault.

Signed operations work on operand magnitudes and correct the signs once the loop has finished. Multiply and divide share one control sequencer.

Top module: `hilo_muldiv`

## Requirements
- R1: After reset, `busy` and `done` are 0 and both HI and LO are 0.
- R2: Function 0x18 forms the signed product of `op_a` and `op_b`: LO receives bits 31:0 and HI receives bits 63:32.
- R3: Function 0x19 forms the unsigned product, with the same split between LO and HI.
- R4: Function 0x1A divides signed operands. LO takes the quotient truncated toward zero. HI takes the remainder, which has the sign of the dividend. The case of the most negative value divided by -1 wraps to a quotient of 0x80000000 and a remainder of 0.
- R5: Function 0x1B divides unsigned operands. LO takes the quotient and HI takes the remainder.
- R6: A divide (0x1A or 0x1B) with a zero `op_b` leaves HI = 0 and LO = 0.
- R7: Function 0x11 loads HI from `move_in`, and 0x13 loads LO from `move_in`. The new value is visible the cycle after the start cycle, and neither `busy` nor `done` is raised.
- R8: `rd_data` shows HI while `func` is 0x10 and LO while `func` is 0x12. For any other code it is 0. It does not depend on `start`.
- R9: After a multiply or divide is accepted at clock edge E0, `busy` is 1 after edges E1 to E32. After edge E33 (W+1 edges), `busy` is 0 and `done` is 1 for exactly one cycle.
- R10: A `start` that arrives while `busy` is 1 is ignored, whatever its code, including move codes.
- R11: HI and LO keep their previous values while an operation runs and change only at the edge that raises `done`.
- R12: A `start` with a code outside the eight listed here changes nothing and does not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe |
| func | input | 6 | Function code |
| op_a | input | 32 | First source operand (multiplicand / dividend) |
| op_b | input | 32 | Second source operand (multiplier / divisor) |
| move_in | input | 32 | Value for moves into HI or LO |
| busy | output | 1 | Multiply or divide in progress |
| done | output | 1 | One-cycle pulse when HI/LO written |
| rd_data | output | 32 | HI or LO read for move-out codes |

## Verification
Signed operations are tested with every sign combination. A design that gets the sign correction wrong returns a wrong sign on the quotient or remainder, or a wrong high product word, in one of these cases. The bench also divides the most negative value by -1 and divides by zero. A design without the zero guard leaves all-ones in LO, and a design that mishandles the most negative value overflows differently. Start pulses, including move requests, arrive while an operation is running: a design without the busy guard would restart or overwrite HI. The bench checks that `done` arrives on exactly the right edge and that HI stays at its old value until then. A unit that is one iteration short fails the timing check, and one that writes early fails the HI/LO check.

// File: rtl/hilo_muldiv_pkg.sv
package hilo_muldiv_pkg;
   typedef enum logic [5:0] {
      FN_RDHI = 6'h10,
      FN_WRHI = 6'h11,
      FN_RDLO = 6'h12,
      FN_WRLO = 6'h13,
      FN_MULS = 6'h18,
      FN_MULU = 6'h19,
      FN_DIVS = 6'h1A,
      FN_DIVU = 6'h1B
   } hl_func_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_ITER = 2'd1,
      SQ_FIX  = 2'd2
   } hl_seq_e;
endpackage

// File: rtl/hl_mul_core.sv
module hl_mul_core #(
   parameter int W = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           step,
   input  logic [W-1:0]   mcand_in,
   input  logic [W-1:0]   mplier_in,
   output logic [2*W-1:0] prod
);
   logic [W-1:0]   mcand_q;
   logic [2*W-1:0] acc_q;
   logic [W:0]     upper_sum;

   always_comb upper_sum = {1'b0, acc_q[2*W-1:W]} + (acc_q[0] ? {1'b0, mcand_q} : '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mcand_q <= '0;
         acc_q   <= '0;
      end else if (load) begin
         mcand_q <= mcand_in;
         acc_q   <= {{W{1'b0}}, mplier_in};
      end else if (step) begin
         acc_q   <= {upper_sum, acc_q[W-1:1]};
      end
   end

   assign prod = acc_q;
endmodule

// File: rtl/hl_div_core.sv
module hl_div_core #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] dvd_in,
   input  logic [W-1:0] dsor_in,
   output logic [W-1:0] quo,
   output logic [W-1:0] rem
);
   logic [W-1:0] dsor_q, quo_q, rem_q;
   logic [W:0]   trial;

   always_comb trial = {rem_q, quo_q[W-1]} - {1'b0, dsor_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dsor_q <= '0;
         quo_q  <= '0;
         rem_q  <= '0;
      end else if (load) begin
         dsor_q <= dsor_in;
         quo_q  <= dvd_in;
         rem_q  <= '0;
      end else if (step) begin
         if (!trial[W]) begin
            rem_q <= trial[W-1:0];
            quo_q <= {quo_q[W-2:0], 1'b1};
         end else begin
            rem_q <= {rem_q[W-2:0], quo_q[W-1]};
            quo_q <= {quo_q[W-2:0], 1'b0};
         end
      end
   end

   assign quo = quo_q;
   assign rem = rem_q;

   // R5: restoring loop keeps the partial remainder below a nonzero divisor
   a_r5_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && dsor_q != '0) |=> (rem_q < dsor_q));
endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
   import hilo_muldiv_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [5:0]   func,
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  logic [W-1:0] move_in,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] rd_data
);
   localparam int CW = $clog2(W);
   localparam logic [CW-1:0] LAST_IT = CW'(W - 1);

   generate
      if (W < 4 || (W & (W - 1)) != 0) begin : g_bad_width
         $error("hilo_muldiv: W must be a power of two of at least 4");
      end
   endgenerate

   hl_seq_e        seq_q;
   logic [CW-1:0]  it_q;
   logic [W-1:0]   hi_q, lo_q;
   logic           done_q, is_div_q, neg_main_q, neg_rem_q, zero_q;
   logic           is_arith, signed_op, take_arith;
   logic [W-1:0]   mag_a, mag_b, quo, rem, fix_q, fix_r;
   logic [2*W-1:0] prod, fix_p;

   always_comb begin
      is_arith   = (func == FN_MULS) || (func == FN_MULU) ||
                   (func == FN_DIVS) || (func == FN_DIVU);
      signed_op  = ~func[0];
      take_arith = start && (seq_q == SQ_IDLE) && is_arith;
      mag_a      = (signed_op && op_a[W-1]) ? (~op_a + 1'b1) : op_a;
      mag_b      = (signed_op && op_b[W-1]) ? (~op_b + 1'b1) : op_b;
   end

   hl_mul_core #(.W(W)) u_mul (
      .clk(clk), .rst_n(rst_n), .load(take_arith), .step(seq_q == SQ_ITER),
      .mcand_in(mag_a), .mplier_in(mag_b), .prod(prod));

   hl_div_core #(.W(W)) u_div (
      .clk(clk), .rst_n(rst_n), .load(take_arith), .step(seq_q == SQ_ITER),
      .dvd_in(mag_a), .dsor_in(mag_b), .quo(quo), .rem(rem));

   always_comb begin
      fix_p = neg_main_q ? (~prod + 1'b1) : prod;
      fix_q = neg_main_q ? (~quo + 1'b1) : quo;
      fix_r = neg_rem_q  ? (~rem + 1'b1) : rem;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seq_q      <= SQ_IDLE;
         it_q       <= '0;
         hi_q       <= '0;
         lo_q       <= '0;
         done_q     <= 1'b0;
         is_div_q   <= 1'b0;
         neg_main_q <= 1'b0;
         neg_rem_q  <= 1'b0;
         zero_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (seq_q)
            SQ_IDLE: if (start) begin
               if (is_arith) begin
                  seq_q      <= SQ_ITER;
                  it_q       <= '0;
                  is_div_q   <= func[1];
                  neg_main_q <= signed_op && (op_a[W-1] ^ op_b[W-1]);
                  neg_rem_q  <= signed_op && op_a[W-1];
                  zero_q     <= (op_b == '0);
               end else if (func == FN_WRHI) begin
                  hi_q <= move_in;
               end else if (func == FN_WRLO) begin
                  lo_q <= move_in;
               end
            end
            SQ_ITER: begin
               it_q <= it_q + 1'b1;
               if (it_q == LAST_IT) seq_q <= SQ_FIX;
            end
            SQ_FIX: begin
               if (!is_div_q) begin
                  hi_q <= fix_p[2*W-1:W];
                  lo_q <= fix_p[W-1:0];
               end else if (zero_q) begin
                  hi_q <= '0;
                  lo_q <= '0;
               end else begin
                  hi_q <= fix_r;
                  lo_q <= fix_q;
               end
               done_q <= 1'b1;
               seq_q  <= SQ_IDLE;
            end
            default: seq_q <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      if (func == FN_RDHI)      rd_data = hi_q;
      else if (func == FN_RDLO) rd_data = lo_q;
      else                      rd_data = '0;
   end

   assign busy = (seq_q != SQ_IDLE);
   assign done = done_q;

   // R9: done lasts one cycle and never overlaps busy
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R9: the loop stays in iteration until its last count
   a_r9_iter_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_q == SQ_ITER && it_q != LAST_IT) |=> (seq_q == SQ_ITER));
   // R11: result registers untouched during the iterations
   a_r11_hilo_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_q == SQ_ITER) |=> ($stable(hi_q) && $stable(lo_q)));
   // R10: a request while busy does not alter the captured operation
   a_r10_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(is_div_q) && $stable(neg_main_q) && $stable(zero_q)));
   // R6: zero divisor empties both halves
   a_r6_zero_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_q == SQ_FIX && is_div_q && zero_q) |=> (hi_q == '0 && lo_q == '0));
endmodule

// File: tb/hilo_muldiv_tb.sv
module hilo_muldiv_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W = 32;
   localparam int LAT = W + 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [5:0]   func = 6'h00;
   logic [W-1:0] op_a = '0, op_b = '0, move_in = '0;
   logic         busy, done;
   logic [W-1:0] rd_data;

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hilo_muldiv #(.W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .func(func), .op_a(op_a),
      .op_b(op_b), .move_in(move_in), .busy(busy), .done(done), .rd_data(rd_data));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic read_hilo(output logic [W-1:0] hi, output logic [W-1:0] lo);
      func = 6'h10; #1 hi = rd_data;
      func = 6'h12; #1 lo = rd_data;
      func = 6'h00;
   endtask

   task automatic run_op(input logic [5:0] f, input logic [W-1:0] a, input logic [W-1:0] b,
                         output int lat);
      @(negedge clk);
      start = 1'b1; func = f; op_a = a; op_b = b;
      @(negedge clk);
      start = 1'b0; func = 6'h00;
      lat = 0;
      while (!done && lat < 200) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic arith_case(input string req, input logic [5:0] f,
                             input logic [W-1:0] a, input logic [W-1:0] b);
      longint sa, sb, q, r;
      logic [63:0] p;
      logic [W-1:0] ehi, elo, hi, lo;
      int lat;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      case (f)
         6'h18: begin p = 64'(sa * sb); ehi = p[63:32]; elo = p[31:0]; end
         6'h19: begin p = {32'h0, a} * {32'h0, b}; ehi = p[63:32]; elo = p[31:0]; end
         6'h1A: if (b == 0) begin ehi = 0; elo = 0; end
                else begin q = sa / sb; r = sa % sb; elo = q[31:0]; ehi = r[31:0]; end
         default: if (b == 0) begin ehi = 0; elo = 0; end
                  else begin elo = a / b; ehi = a % b; end
      endcase
      run_op(f, a, b, lat);
      check({req, " latency R9"}, 64'(lat), 64'(LAT));
      read_hilo(hi, lo);
      check({req, " HI"}, 64'(hi), 64'(ehi));
      check({req, " LO"}, 64'(lo), 64'(elo));
   endtask

   task automatic t_reset;
      logic [W-1:0] hi, lo;
      check("R1 busy", 64'(busy), 0);
      check("R1 done", 64'(done), 0);
      read_hilo(hi, lo);
      check("R1 HI", 64'(hi), 0);
      check("R1 LO", 64'(lo), 0);
   endtask

   task automatic t_moves;
      logic [W-1:0] hi, lo;
      @(negedge clk); start = 1; func = 6'h11; move_in = 32'hCAFE_0011;
      @(negedge clk); start = 1; func = 6'h13; move_in = 32'h1234_5678;
      check("R7 no busy after MTHI", 64'(busy), 0);
      @(negedge clk); start = 0; func = 6'h00;
      check("R7 no busy", 64'(busy), 0);
      check("R7 no done", 64'(done), 0);
      read_hilo(hi, lo);
      check("R7 HI", 64'(hi), 64'h0000_0000_CAFE_0011);
      check("R7 LO", 64'(lo), 64'h0000_0000_1234_5678);
      start = 1; func = 6'h10; #1;
      check("R8 MFHI with start", 64'(rd_data), 64'h0000_0000_CAFE_0011);
      func = 6'h12; #1;
      check("R8 MFLO with start", 64'(rd_data), 64'h0000_0000_1234_5678);
      func = 6'h2A; #1;
      check("R8 other code reads zero", 64'(rd_data), 0);
      func = 6'h00; start = 0;
   endtask

   task automatic t_bad_code;
      logic [W-1:0] hi, lo;
      @(negedge clk); start = 1; func = 6'h20; op_a = 7; op_b = 9; move_in = 32'hFFFF_FFFF;
      @(negedge clk); start = 0; func = 6'h00;
      check("R12 no busy", 64'(busy), 0);
      @(negedge clk);
      read_hilo(hi, lo);
      check("R12 HI kept", 64'(hi), 64'h0000_0000_CAFE_0011);
      check("R12 LO kept", 64'(lo), 64'h0000_0000_1234_5678);
   endtask

   task automatic t_busy_ignore;
      logic [W-1:0] hi, lo;
      int lat;
      @(negedge clk); start = 1; func = 6'h19; op_a = 3; op_b = 5;
      @(negedge clk); start = 0; func = 6'h00;
      check("R9 busy after accept", 64'(busy), 1);
      repeat (3) @(negedge clk);
      start = 1; func = 6'h1A; op_a = 100; op_b = 0;
      @(negedge clk); func = 6'h11; move_in = 32'hDEAD_BEEF;
      @(negedge clk); start = 0;
      func = 6'h10; #1;
      check("R11 HI old while busy", 64'(rd_data), 64'h0000_0000_CAFE_0011);
      func = 6'h00;
      lat = 5;
      while (!done && lat < 200) begin @(negedge clk); lat++; end
      check("R10 latency unchanged", 64'(lat), 64'(LAT));
      read_hilo(hi, lo);
      check("R10 HI", 64'(hi), 0);
      check("R10 LO", 64'(lo), 15);
      @(negedge clk);
      check("R9 done one cycle", 64'(done), 0);
      check("R10 idle again", 64'(busy), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_moves();
      t_bad_code();
      arith_case("R2 pos*pos", 6'h18, 32'd1234, 32'd5678);
      arith_case("R2 neg*pos", 6'h18, -32'sd7, 32'd9);
      arith_case("R2 neg*neg", 6'h18, 32'h8000_0000, 32'h8000_0000);
      arith_case("R2 pos*neg", 6'h18, 32'h7FFF_FFFF, -32'sd3);
      arith_case("R3 large", 6'h19, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      arith_case("R3 mixed", 6'h19, 32'h8000_0001, 32'd3);
      arith_case("R4 -7/2", 6'h1A, -32'sd7, 32'd2);
      arith_case("R4 7/-2", 6'h1A, 32'd7, -32'sd2);
      arith_case("R4 -7/-2", 6'h1A, -32'sd7, -32'sd2);
      arith_case("R4 min/-1", 6'h1A, 32'h8000_0000, 32'hFFFF_FFFF);
      arith_case("R5 basic", 6'h1B, 32'd1000, 32'd7);
      arith_case("R5 high bit", 6'h1B, 32'hFFFF_FFF0, 32'h8000_0000);
      arith_case("R6 signed zero", 6'h1A, 32'd55, 32'd0);
      arith_case("R6 unsigned zero", 6'h1B, 32'hFFFF_FFFF, 32'd0);
      t_moves();
      t_busy_ignore();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule